// File: doc/BRIEF.md
# Vector Integer Compare-to-Mask Engine

This engine executes one vector integer comparison over a whole register group. It steps through the elements one per clock and writes a single result bit per element into a destination mask. A start pulse captures the whole instruction context: the comparison kind, the element width, the operand source (second vector, scalar or 5-bit immediate), the active length `vl`, the mask-enable flag and its v0 mask, the mask stride, the flat source buffers and the prior contents of the destination mask.

The engine derives the element count of the group (vlmax) from the group size parameter and the element width. It then visits every index up to vlmax-1. Active elements receive the comparison result. Elements disabled by v0 keep their old bit. Tail elements are cleared. An instruction with `vl` of zero leaves the destination as it was. `busy_o` covers the whole run, and `done_o` marks the cycle in which `dest_o` holds the finished mask.

Top module: `cmpm_unit`

## Requirements
- R1: Each result bit is `vs2[i] OP operand`, with vs2 as the left operand. Element i of width SEW is taken little-endian from bits `[i*SEW +: SEW]` of its buffer. The op codes are: 0 equal, 1 not-equal, 2 unsigned less-than, 3 signed less-than, 4 unsigned less-or-equal, 5 signed less-or-equal, 6 unsigned greater-than, 7 signed greater-than.
- R2: Op codes 3, 5 and 7 compare as two's-complement values of SEW bits. Op codes 2, 4 and 6 compare as unsigned values. `sew_i` is encoded 0=8, 1=16, 2=32, 3=64 bits.
- R3: With `form_i`=1 (scalar), only the low SEW bits of `scalar_i` are used. They are then read as signed or unsigned to match the op. `form_i`=0 selects the vs1 buffer.
- R4: With `form_i`=2 (immediate), `imm_i` is zero-extended for op codes 4 and 6 and sign-extended for every other op. It is then cut to SEW bits.
- R5: When `vm_i`=0 and v0 bit `i*mlen` is 0, destination bit `i*mlen` keeps its previous value for an element i below vl.
- R6: For i from vl up to vlmax-1, destination bit `i*mlen` is written 0, whatever the mask says.
- R7: With `vl_i`=0, the destination equals `dest_i` unchanged, tail included.
- R8: The result for element i lands at bit `i*mlen_i` of `dest_o`, and the mask for element i is read from bit `i*mlen_i` of `v0_i`. Bits at other positions keep the value they had in `dest_i`.
- R9: vlmax is GROUP_BYTES divided by SEW/8. One element is handled per clock. `done_o` is high for exactly one cycle, vlmax+1 clocks after the edge that samples `start_i` (2 clocks when vl=0).
- R10: `busy_o` is high from the clock after start until done. A start pulse while busy is ignored.
- R11: With `vm_i`=1, every element below vl is written regardless of v0.
- R12: After reset, `busy_o`=0, `done_o`=0 and `dest_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, sampled while idle |
| op_i | input | 3 | Comparison kind |
| form_i | input | 2 | Operand source: 0 vector, 1 scalar, 2 immediate |
| sew_i | input | 2 | Element width code |
| vl_i | input | IDX_W | Active vector length |
| vm_i | input | 1 | 1 disables masking |
| mlen_i | input | MLEN_W | Mask bit stride |
| v0_i | input | MASK_BITS | Mask register v0 |
| vs1_i | input | GROUP_BYTES*8 | Second source vector group |
| vs2_i | input | GROUP_BYTES*8 | First source vector group (left operand) |
| scalar_i | input | 64 | Scalar operand |
| imm_i | input | 5 | Immediate operand |
| dest_i | input | MASK_BITS | Prior destination mask |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle completion pulse |
| dest_o | output | MASK_BITS | Destination mask |

## Verification
Every mask is complete in the cycle in which `done_o` is high. For a nonzero vl, that cycle comes vlmax+1 clocks after the start edge, because one clock is spent capturing the context and one clock is spent per element. With vl of zero, it comes after two clocks. The driver records the cycle count at each start and queues the expected mask and latency. The monitor samples on the falling edge, so whenever it sees `done_o` it compares both the mask and the elapsed clocks against the head of the queue. A `done_o` with nothing queued is a failure. This also catches an extra run caused by a start pulse issued while busy.

// File: rtl/cmpm_pkg.sv
package cmpm_pkg;

   typedef enum logic [2:0] {
      CMP_EQ  = 3'd0,
      CMP_NE  = 3'd1,
      CMP_LTU = 3'd2,
      CMP_LT  = 3'd3,
      CMP_LEU = 3'd4,
      CMP_LE  = 3'd5,
      CMP_GTU = 3'd6,
      CMP_GT  = 3'd7
   } cmp_op_e;

   typedef enum logic [1:0] {
      SRC_VEC    = 2'd0,
      SRC_SCALAR = 2'd1,
      SRC_IMM    = 2'd2
   } src_form_e;

   // signed interpretation of both operands
   function automatic logic op_is_signed(input logic [2:0] op);
      return (op == CMP_LT) || (op == CMP_LE) || (op == CMP_GT);
   endfunction

   // immediate forms that take a zero-extended constant
   function automatic logic imm_zero_ext(input logic [2:0] op);
      return (op == CMP_LEU) || (op == CMP_GTU);
   endfunction

   // widen a SEW-bit value to 65 bits so one signed comparator serves all kinds
   function automatic logic [64:0] widen(input logic [63:0] v, input logic [1:0] sew,
                                         input logic sgn);
      case (sew)
         2'd0:    return {{57{sgn & v[7]}},  v[7:0]};
         2'd1:    return {{49{sgn & v[15]}}, v[15:0]};
         2'd2:    return {{33{sgn & v[31]}}, v[31:0]};
         default: return {sgn & v[63], v};
      endcase
   endfunction

endpackage

// File: rtl/cmpm_elem_pick.sv
module cmpm_elem_pick #(
   parameter int GROUP_BYTES = 16,
   parameter int IDX_W       = 5
) (
   input  logic [GROUP_BYTES*8-1:0] data_i,
   input  logic [IDX_W-1:0]         idx_i,
   input  logic [1:0]               sew_i,
   output logic [63:0]              elem_o
);
   logic [63:0] cand [4];

   for (genvar k = 0; k < 4; k++) begin : g_width
      localparam int W   = 8 << k;
      localparam int CNT = GROUP_BYTES >> k;
      localparam int LW  = $clog2(CNT);
      logic [LW-1:0] slot;
      assign slot     = idx_i[LW-1:0];
      assign cand[k]  = 64'(data_i[slot*W +: W]);
   end

   assign elem_o = cand[sew_i];
endmodule

// File: rtl/cmpm_operand.sv
module cmpm_operand
   import cmpm_pkg::*;
(
   input  logic [63:0] vs2_elem_i,
   input  logic [63:0] vs1_elem_i,
   input  logic [63:0] scalar_i,
   input  logic [4:0]  imm_i,
   input  logic [2:0]  op_i,
   input  logic [1:0]  form_i,
   input  logic [1:0]  sew_i,
   output logic [64:0] lhs_o,
   output logic [64:0] rhs_o
);
   logic [63:0] rhs_raw;
   logic        sgn;

   always_comb begin
      case (form_i)
         SRC_SCALAR: rhs_raw = scalar_i;
         SRC_IMM:    rhs_raw = imm_zero_ext(op_i) ? {59'd0, imm_i}
                                                  : {{59{imm_i[4]}}, imm_i};
         default:    rhs_raw = vs1_elem_i;
      endcase
   end

   assign sgn   = op_is_signed(op_i);
   assign lhs_o = widen(vs2_elem_i, sew_i, sgn);
   assign rhs_o = widen(rhs_raw, sew_i, sgn);
endmodule

// File: rtl/cmpm_alu.sv
module cmpm_alu
   import cmpm_pkg::*;
(
   input  logic [64:0] lhs_i,
   input  logic [64:0] rhs_i,
   input  logic [2:0]  op_i,
   output logic        hit_o
);
   logic lt, eq;
   assign lt = $signed(lhs_i) < $signed(rhs_i);
   assign eq = (lhs_i == rhs_i);

   always_comb begin
      case (op_i)
         CMP_EQ:           hit_o = eq;
         CMP_NE:           hit_o = !eq;
         CMP_LTU, CMP_LT:  hit_o = lt;
         CMP_LEU, CMP_LE:  hit_o = lt | eq;
         default:          hit_o = !(lt | eq);
      endcase
   end
endmodule

// File: rtl/cmpm_unit.sv
module cmpm_unit
   import cmpm_pkg::*;
#(
   parameter int GROUP_BYTES = 16,
   parameter int MASK_BITS   = 128,
   parameter int MLEN_W      = 8,
   localparam int GROUP_BITS = GROUP_BYTES * 8,
   localparam int IDX_W      = $clog2(GROUP_BYTES + 1)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start_i,
   input  logic [2:0]             op_i,
   input  logic [1:0]             form_i,
   input  logic [1:0]             sew_i,
   input  logic [IDX_W-1:0]       vl_i,
   input  logic                   vm_i,
   input  logic [MLEN_W-1:0]      mlen_i,
   input  logic [MASK_BITS-1:0]   v0_i,
   input  logic [GROUP_BITS-1:0]  vs1_i,
   input  logic [GROUP_BITS-1:0]  vs2_i,
   input  logic [63:0]            scalar_i,
   input  logic [4:0]             imm_i,
   input  logic [MASK_BITS-1:0]   dest_i,
   output logic                   busy_o,
   output logic                   done_o,
   output logic [MASK_BITS-1:0]   dest_o
);
   localparam int POS_W  = $clog2(MASK_BITS);
   localparam int PROD_W = IDX_W + MLEN_W;

   if (GROUP_BYTES < 16 || (GROUP_BYTES & (GROUP_BYTES - 1)) != 0) begin : g_bad_group
      $error("GROUP_BYTES must be a power of two of at least 16");
   end
   if ((MASK_BITS & (MASK_BITS - 1)) != 0 || MASK_BITS < GROUP_BYTES) begin : g_bad_mask
      $error("MASK_BITS must be a power of two no smaller than GROUP_BYTES");
   end

   logic                  busy_q, done_q, vm_q;
   logic [IDX_W-1:0]      idx_q, vl_q, vlmax_q;
   logic [2:0]            op_q;
   logic [1:0]            form_q, sew_q;
   logic [MLEN_W-1:0]     mlen_q;
   logic [MASK_BITS-1:0]  v0_q, dest_q;
   logic [GROUP_BITS-1:0] vs1_q, vs2_q;
   logic [63:0]           scalar_q;
   logic [4:0]            imm_q;

   logic [63:0]           e2, e1;
   logic [64:0]           lhs, rhs;
   logic                  hit, last, in_tail, enabled;
   logic [PROD_W-1:0]     pos_full;
   logic [POS_W-1:0]      pos;

   cmpm_elem_pick #(.GROUP_BYTES(GROUP_BYTES), .IDX_W(IDX_W)) i_pick2 (
      .data_i(vs2_q), .idx_i(idx_q), .sew_i(sew_q), .elem_o(e2));
   cmpm_elem_pick #(.GROUP_BYTES(GROUP_BYTES), .IDX_W(IDX_W)) i_pick1 (
      .data_i(vs1_q), .idx_i(idx_q), .sew_i(sew_q), .elem_o(e1));

   cmpm_operand i_opnd (
      .vs2_elem_i(e2), .vs1_elem_i(e1), .scalar_i(scalar_q), .imm_i(imm_q),
      .op_i(op_q), .form_i(form_q), .sew_i(sew_q), .lhs_o(lhs), .rhs_o(rhs));

   cmpm_alu i_alu (.lhs_i(lhs), .rhs_i(rhs), .op_i(op_q), .hit_o(hit));

   assign pos_full = PROD_W'(idx_q) * PROD_W'(mlen_q);
   assign pos      = pos_full[POS_W-1:0];
   assign last     = (idx_q == IDX_W'(vlmax_q - 1'b1));
   assign in_tail  = (idx_q >= vl_q);
   assign enabled  = vm_q | v0_q[pos];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;  done_q <= 1'b0;  vm_q <= 1'b0;
         idx_q <= '0;  vl_q <= '0;  vlmax_q <= '0;
         op_q <= '0;  form_q <= '0;  sew_q <= '0;  mlen_q <= '0;
         v0_q <= '0;  dest_q <= '0;  vs1_q <= '0;  vs2_q <= '0;
         scalar_q <= '0;  imm_q <= '0;
      end else begin
         done_q <= 1'b0;
         if (!busy_q) begin
            if (start_i) begin
               busy_q   <= 1'b1;
               idx_q    <= '0;
               vl_q     <= vl_i;
               vlmax_q  <= IDX_W'(GROUP_BYTES >> sew_i);
               op_q     <= op_i;    form_q <= form_i;  sew_q  <= sew_i;
               vm_q     <= vm_i;    mlen_q <= mlen_i;  v0_q   <= v0_i;
               vs1_q    <= vs1_i;   vs2_q  <= vs2_i;
               scalar_q <= scalar_i; imm_q <= imm_i;
               dest_q   <= dest_i;
            end
         end else if (vl_q == '0) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
         end else begin
            if (in_tail)      dest_q[pos] <= 1'b0;
            else if (enabled) dest_q[pos] <= hit;
            if (last) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end else begin
               idx_q <= idx_q + 1'b1;
            end
         end
      end
   end

   assign busy_o = busy_q;
   assign done_o = done_q;
   assign dest_o = dest_q;

   // R5: a disabled active element leaves the whole mask as it was
   a_r5_masked_keep: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && vl_q != '0 && !in_tail && !vm_q && !v0_q[pos]) |=> $stable(dest_q));
   // R6: a tail element clears its bit
   a_r6_tail_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && vl_q != '0 && in_tail) |=> !dest_q[$past(pos)]);
   // R7: a zero-length run changes nothing
   a_r7_vl_zero_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && vl_q == '0) |=> $stable(dest_q));
   // R9: done is a single-cycle pulse and comes only after the last index
   a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);
   a_r9_no_early_done: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && vl_q != '0 && !last) |=> !done_q);
   // R10: start while idle raises busy; busy and done never overlap
   a_r10_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_q && start_i) |=> busy_q);
   a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> !busy_q);
   a_r10_ignore_start: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !last && vl_q != '0) |=> $stable(op_q) && $stable(vs2_q));
endmodule

// File: tb/test_cmpm_unit.sv
module test_cmpm_unit;
   localparam int GB = 16;
   localparam int MB = 128;
   localparam int IW = $clog2(GB + 1);

   logic           clk = 1'b0, rst_n = 1'b0, start = 1'b0, vm = 1'b1;
   logic [2:0]     op = '0;
   logic [1:0]     form = '0, sew = '0;
   logic [IW-1:0]  vl = '0;
   logic [7:0]     mlen = 8'd1;
   logic [MB-1:0]  v0 = '0, din = '0;
   logic [GB*8-1:0] vs1 = '0, vs2 = '0;
   logic [63:0]    sc = '0;
   logic [4:0]     imm = '0;
   logic           busy, done;
   logic [MB-1:0]  dout;

   cmpm_unit #(.GROUP_BYTES(GB), .MASK_BITS(MB), .MLEN_W(8)) i_cmpm_unit (
      .clk(clk), .rst_n(rst_n), .start_i(start), .op_i(op), .form_i(form),
      .sew_i(sew), .vl_i(vl), .vm_i(vm), .mlen_i(mlen), .v0_i(v0),
      .vs1_i(vs1), .vs2_i(vs2), .scalar_i(sc), .imm_i(imm), .dest_i(din),
      .busy_o(busy), .done_o(done), .dest_o(dout));

   initial forever #10 clk = ~clk;

   typedef struct {
      logic [MB-1:0] mask;
      int            t0;
      int            lat;
      string         tag;
   } exp_t;

   exp_t q[$];
   exp_t e;
   int checks = 0, fails = 0, cyc = 0;
   bit ended = 0;

   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [MB-1:0] model(input int o, input int f, input int s,
         input int l, input bit m, input int ml, input logic [MB-1:0] mv0,
         input logic [GB*8-1:0] a1, input logic [GB*8-1:0] a2, input logic [63:0] x,
         input logic [4:0] k, input logic [MB-1:0] d);
      logic [MB-1:0] r;
      logic [63:0] a, b, bx;
      bit res;
      int w, n;
      r = d;
      w = 8 << s;
      n = GB >> s;
      if (l == 0) return d;
      for (int i = 0; i < n; i++) begin
         int p;
         p = i * ml;
         if (i >= l) begin r[p] = 1'b0; continue; end
         if (!m && !mv0[p]) continue;
         a = 64'(a2 >> (i * w)) << (64 - w);
         if (f == 0)      bx = 64'(a1 >> (i * w));
         else if (f == 1) bx = x;
         else             bx = (o == 4 || o == 6) ? {59'd0, k} : {{59{k[4]}}, k};
         b = bx << (64 - w);
         case (o)
            0: res = (a == b);
            1: res = (a != b);
            2: res = (a < b);
            3: res = ($signed(a) < $signed(b));
            4: res = (a <= b);
            5: res = ($signed(a) <= $signed(b));
            6: res = (a > b);
            default: res = ($signed(a) > $signed(b));
         endcase
         r[p] = res;
      end
      return r;
   endfunction

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [MB-1:0] act, input logic [MB-1:0] ex);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, ex);
      end
   endtask

   // monitor: compares each finished mask and its latency with the queue head
   always @(negedge clk) begin
      if (rst_n && done && !ended) begin
         if (q.size() == 0) begin
            check(1'b0, "R10", "unexpected done", dout, '0);
         end else begin
            e = q.pop_front();
            check(dout == e.mask, e.tag, "mask", dout, e.mask);
            check((cyc - e.t0) == e.lat, "R9", "latency",
                  MB'(cyc - e.t0), MB'(e.lat));
         end
      end
   end

   task automatic run(input int o, input int f, input int s, input int l, input bit m,
         input int ml, input logic [MB-1:0] mv0, input logic [GB*8-1:0] a1,
         input logic [GB*8-1:0] a2, input logic [63:0] x, input logic [4:0] k,
         input logic [MB-1:0] d, input string tag, input bit poke);
      exp_t it;
      @(negedge clk);
      op = 3'(o); form = 2'(f); sew = 2'(s); vl = IW'(l); vm = m; mlen = 8'(ml);
      v0 = mv0; vs1 = a1; vs2 = a2; sc = x; imm = k; din = d;
      it.mask = model(o, f, s, l, m, ml, mv0, a1, a2, x, k, d);
      it.t0   = cyc;
      it.lat  = 1 + ((l == 0) ? 1 : (GB >> s));
      it.tag  = tag;
      q.push_back(it);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(busy == 1'b1, "R10", "busy after start", MB'(busy), MB'(1));
      if (poke) begin
         @(negedge clk);
         op = ~op; vs2 = ~vs2; din = ~din; start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      while (busy) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog R9 actual=hung expected=finished");
      finish_run();
   end

   initial begin
      logic [GB*8-1:0] ra, rb;
      logic [MB-1:0]   ones;
      ones = '1;
      ra = {$urandom(7), $urandom, $urandom, $urandom};
      rb = {$urandom, $urandom, $urandom, $urandom};
      repeat (3) @(negedge clk);
      // R12: reset values
      check(busy == 1'b0, "R12", "busy", MB'(busy), '0);
      check(done == 1'b0, "R12", "done", MB'(done), '0);
      check(dout == '0,   "R12", "dest", dout, '0);
      rst_n = 1'b1;

      // R1 R11: equal, vector form, bytes 3 and 9 differ, unmasked
      run(0, 0, 0, 16, 1, 1, '0, ra ^ {48'd0, 8'h40, 40'd0, 8'h01, 24'd0}, ra, 0, 0, '0,
          "R1 R11", 0);
      // R3 R6 R8: not-equal against a scalar, sew 16, vl 5, stride 2
      run(1, 1, 1, 5, 1, 2, '0, '0, {rb[127:32], 16'h1234, rb[15:0]},
          64'hFFFF_0000_5555_1234, 0, ones, "R3 R6 R8", 0);
      // R2: unsigned and signed less-than on the same 32-bit data
      run(2, 0, 2, 4, 1, 1, '0,
          {32'h8000_0000, 32'h7FFF_FFFF, 32'h0000_0001, 32'h0000_0000},
          {32'h7FFF_FFFF, 32'h8000_0000, 32'h0000_0001, 32'hFFFF_FFFF}, 0, 0, '0, "R2", 0);
      run(3, 0, 2, 4, 1, 1, '0,
          {32'h8000_0000, 32'h7FFF_FFFF, 32'h0000_0001, 32'h0000_0000},
          {32'h7FFF_FFFF, 32'h8000_0000, 32'h0000_0001, 32'hFFFF_FFFF}, 0, 0, '0, "R2", 0);
      // R4: immediate 5'b11111 is 31 for unsigned le, -1 for signed le
      run(4, 2, 0, 16, 1, 1, '0, '0,
          {8'h00, 8'h1E, 8'h1F, 8'h20, 8'hFF, 8'h80, 8'h7F, 8'h01, 64'h1F20_FF00_1E05_8140},
          0, 5'h1F, '0, "R4", 0);
      run(5, 2, 0, 16, 1, 1, '0, '0,
          {8'h00, 8'h1E, 8'h1F, 8'h20, 8'hFF, 8'h80, 8'h7F, 8'h01, 64'h1F20_FF00_1E05_8140},
          0, 5'h1F, '0, "R4", 0);
      run(6, 2, 1, 8, 1, 1, '0, '0, rb, 0, 5'h10, '0, "R4", 0);
      // R3: scalar upper bits discarded for sew 32, unsigned greater-than
      run(6, 1, 2, 4, 1, 3, '0, '0,
          {32'h0000_0006, 32'h0000_0005, 32'hFFFF_FFFF, 32'h0000_0004},
          64'hFFFF_FFFF_0000_0005, 0, '0, "R3", 0);
      // R1 R2: signed greater-than, sew 64, negative scalar
      run(7, 1, 3, 2, 1, 5, '0, '0, {64'hFFFF_FFFF_FFFF_FFFE, 64'h0000_0000_0000_0003},
          64'hFFFF_FFFF_FFFF_FFFF, 0, '0, "R1 R2", 0);
      // R5 R6 R8: masked signed less-than, stride 4, vl 6, old mask all ones
      run(3, 0, 1, 6, 0, 4, {{96{1'b0}}, 32'h0101_1010}, ra, rb, 0, 0, ones,
          "R5 R6 R8", 0);
      // R5: every element disabled keeps a random old mask below vl
      run(0, 0, 0, 16, 0, 1, '0, ra, ra, 0, 0, {ra[63:0], rb[63:0]}, "R5", 0);
      // R7: zero length leaves a random destination untouched
      run(1, 0, 0, 0, 1, 1, '0, ra, rb, 0, 0, {rb[63:0], ra[63:0]}, "R7", 0);
      // R10: a start pulse during a run is ignored
      run(0, 0, 0, 16, 1, 8, '0, ra, ra, 0, 0, '0, "R10", 1);
      check(q.size() == 0, "R10", "pending results", MB'(q.size()), '0);
      finish_run();
   end
endmodule